// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a compact processor with one accumulator. It runs a fixed set of six instructions out of one 256-word by 16-bit synchronous memory, and code and data share that memory. Every instruction is one word. The upper byte selects the operation and the lower byte names a memory word. The core drives the memory's address, write-data and write-enable lines and takes in the registered read data. The program counter and the accumulator are brought out so that a system can watch the architectural state.

Internally the core holds a program counter, an instruction register holding the opcode, an accumulator, a memory address register and a memory data register. Execution is sequenced by a small state machine. Fetched words come back one clock after their address was driven, so the address lines are chosen combinationally from the current state. Loads, adds, subtracts, jumps and undefined opcodes take two clocks each. A store takes three.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and in the first cycle after release, pc_o is 0x00, acc_o is 0x0000, mem_addr is 0x00 and mem_we is low.
- R2: In the decode cycle of each instruction, mem_addr carries bits 7:0 of the fetched word and pc_o still shows that instruction's own address. In the following cycle pc_o shows that address plus one, unless a jump is taken.
- R3: Opcode 0x01 (bits 15:8) replaces the accumulator with the addressed word. The new value is visible at the next decode cycle, two cycles after this instruction's decode.
- R4: Opcode 0x02 adds the addressed word to the accumulator, modulo 2^16, and keeps no carry.
- R5: Opcode 0x03 subtracts the addressed word from the accumulator, modulo 2^16, and keeps no borrow.
- R6: Opcode 0x04 raises mem_we for exactly one cycle, the cycle after decode, with mem_addr set to the operand and mem_wdata set to the accumulator. In the next cycle mem_addr returns to the incremented program counter with mem_we low, and then the next decode follows.
- R7: Opcode 0x05 loads the program counter with bits 7:0, and the next instruction is fetched from there.
- R8: Opcode 0x06 with accumulator bit 15 set loads the program counter with bits 7:0.
- R9: Opcode 0x06 with accumulator bit 15 clear continues at the incremented program counter.
- R10: Any other opcode leaves the accumulator and memory unchanged and continues at the incremented program counter.
- R11: The program 0x0111, 0x0210, 0x0412, with data words at 0x10 and 0x11, leaves their 16-bit sum at 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 16 | Registered read data from the memory |
| mem_addr | output | 8 | Memory address, selected combinationally from the state |
| mem_wdata | output | 16 | Data to be written |
| mem_we | output | 1 | Write enable, one cycle per store |
| pc_o | output | 8 | Program counter |
| acc_o | output | 16 | Accumulator |

## Verification
Each instruction begins with a decode cycle, which the reference model treats as cycle one. Its address and program-counter results are due in that cycle. The updated program counter and the store's write strobe are due one cycle later. A store's restored address is due in the third cycle. A new accumulator value is due at the next instruction's decode. The bench's model lays out exactly those per-cycle values for each instruction and compares every one of them at the falling edge between rising edges. Memory contents are compared at the end of each program, once every write has landed.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_STORE1 = 3'd3,
        ST_STORE2 = 3'd4,
        ST_FETCH  = 3'd5
    } state_e;

    localparam logic [7:0] OPC_LOAD  = 8'h01;
    localparam logic [7:0] OPC_ADD   = 8'h02;
    localparam logic [7:0] OPC_SUB   = 8'h03;
    localparam logic [7:0] OPC_STORE = 8'h04;
    localparam logic [7:0] OPC_JUMP  = 8'h05;
    localparam logic [7:0] OPC_JNEG  = 8'h06;

    typedef struct packed {
        logic reads_mem;
        logic writes_mem;
        logic jump_always;
        logic jump_if_neg;
    } op_class_t;

endpackage

// File: rtl/acc_opdec.sv
module acc_opdec
    import acc_core_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] opcode,
    output op_class_t      cls
);
    always_comb begin
        cls = '0;
        if (opcode == OPW'(OPC_LOAD) || opcode == OPW'(OPC_ADD) ||
            opcode == OPW'(OPC_SUB)) begin
            cls.reads_mem = 1'b1;
        end
        if (opcode == OPW'(OPC_STORE)) cls.writes_mem  = 1'b1;
        if (opcode == OPW'(OPC_JUMP))  cls.jump_always = 1'b1;
        if (opcode == OPW'(OPC_JNEG))  cls.jump_if_neg = 1'b1;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int OPW = 8,
    parameter int DW  = 16
) (
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  operand,
    output logic [DW-1:0]  result
);
    always_comb begin
        if (opcode == OPW'(OPC_LOAD))      result = operand;
        else if (opcode == OPW'(OPC_ADD))  result = acc + operand;
        else if (opcode == OPW'(OPC_SUB))  result = acc - operand;
        else                               result = acc;
    end
endmodule

// File: rtl/acc_addr_sel.sv
module acc_addr_sel
    import acc_core_pkg::*;
#(
    parameter int AW = 8
) (
    input  state_e        state,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] mar,
    input  logic [AW-1:0] fetched_field,
    output logic [AW-1:0] addr
);
    always_comb begin
        unique case (state)
            ST_RESET:  addr = '0;
            ST_DECODE: addr = fetched_field;
            ST_STORE1: addr = mar;
            default:   addr = pc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o
);
    localparam int OPW = DW - AW;

    typedef struct packed {
        state_e         state;
        logic [AW-1:0]  pc;
        logic [OPW-1:0] ir;
        logic [DW-1:0]  acc;
        logic [AW-1:0]  mar;
        logic [DW-1:0]  mdr;
    } core_t;

    core_t core_d, core_q;

    logic [OPW-1:0] fetched_op;
    logic [AW-1:0]  fetched_field;
    op_class_t      fetched_cls;
    logic [DW-1:0]  alu_result;
    logic           is_decode;
    logic           is_exec;

    assign fetched_op    = mem_rdata[DW-1:AW];
    assign fetched_field = mem_rdata[AW-1:0];

    acc_opdec #(.OPW(OPW)) u_opdec (
        .opcode (fetched_op),
        .cls    (fetched_cls)
    );

    acc_alu #(.OPW(OPW), .DW(DW)) u_alu (
        .opcode  (core_q.ir),
        .acc     (core_q.acc),
        .operand (mem_rdata),
        .result  (alu_result)
    );

    acc_addr_sel #(.AW(AW)) u_addr (
        .state         (core_q.state),
        .pc            (core_q.pc),
        .mar           (core_q.mar),
        .fetched_field (fetched_field),
        .addr          (mem_addr)
    );

    always_comb begin
        core_d = core_q;
        unique case (core_q.state)
            ST_RESET: begin
                core_d.pc    = '0;
                core_d.acc   = '0;
                core_d.state = ST_DECODE;
            end
            ST_FETCH: begin
                core_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                core_d.ir  = fetched_op;
                core_d.mar = fetched_field;
                core_d.pc  = core_q.pc + 1'b1;
                if (fetched_cls.jump_always ||
                    (fetched_cls.jump_if_neg && core_q.acc[DW-1])) begin
                    core_d.pc = fetched_field;
                end
                if (fetched_cls.reads_mem) begin
                    core_d.state = ST_EXEC;
                end else if (fetched_cls.writes_mem) begin
                    core_d.mdr   = core_q.acc;
                    core_d.state = ST_STORE1;
                end else begin
                    core_d.state = ST_FETCH;
                end
            end
            ST_EXEC: begin
                core_d.mdr   = mem_rdata;
                core_d.acc   = alu_result;
                core_d.state = ST_DECODE;
            end
            ST_STORE1: core_d.state = ST_STORE2;
            ST_STORE2: core_d.state = ST_DECODE;
            default:   core_d.state = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_we    = (core_q.state == ST_STORE1);
    assign mem_wdata = core_q.mdr;
    assign pc_o      = core_q.pc;
    assign acc_o     = core_q.acc;
    assign is_decode = (core_q.state == ST_DECODE);
    assign is_exec   = (core_q.state == ST_EXEC);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] mem_rdata,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic [AW-1:0] pc_o,
    input logic [DW-1:0] acc_o,
    input logic          is_decode,
    input logic          is_exec
);
    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            AST_RESET_CLEAR: assert (pc_o == '0 && acc_o == '0); // R1
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_decode && mem_rdata[DW-1:AW] != (DW-AW)'(8'h05) &&
         mem_rdata[DW-1:AW] != (DW-AW)'(8'h06))
        |=> pc_o == AW'($past(pc_o) + 1'b1)); // R2

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (is_decode && mem_rdata[DW-1:AW] == (DW-AW)'(8'h05))
        |=> pc_o == $past(mem_rdata[AW-1:0])); // R7

    AST_JNEG_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (is_decode && mem_rdata[DW-1:AW] == (DW-AW)'(8'h06) && !acc_o[DW-1])
        |=> pc_o == AW'($past(pc_o) + 1'b1)); // R9

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R6

    AST_STORE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == pc_o && $stable(acc_o))); // R6

    AST_ACC_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !is_exec |=> $stable(acc_o)); // R10
endmodule

bind acc_core acc_core_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .pc_o      (pc_o),
    .acc_o     (acc_o),
    .is_decode (is_decode),
    .is_exec   (is_exec)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata = 16'h0000;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [7:0]  pc_o;
    logic [15:0] acc_o;

    logic [15:0] ram     [0:255];
    logic [15:0] ref_ram [0:255];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    acc_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .pc_o      (pc_o),
        .acc_o     (acc_o)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] v);
        ram[a] = v;
        ref_ram[a] = v;
    endtask

    task automatic load_prog(input int which);
        for (int i = 0; i < 256; i++) put(i, 16'h0000);
        case (which)
            0: begin
                put(8'h00, 16'h0111); put(8'h01, 16'h0210);
                put(8'h02, 16'h0412); put(8'h03, 16'h0503);
                put(8'h10, 16'h1234); put(8'h11, 16'h0BBB);
            end
            1: begin
                put(8'h00, 16'h0120); put(8'h01, 16'h0604);
                put(8'h02, 16'h0421); put(8'h03, 16'h0503);
                put(8'h04, 16'h0322); put(8'h05, 16'h060A);
                put(8'h06, 16'h0700); put(8'h07, 16'h0223);
                put(8'h08, 16'h0424); put(8'h09, 16'h0000);
                put(8'h0A, 16'h0425); put(8'h0B, 16'h050B);
                put(8'h20, 16'h8000); put(8'h22, 16'h0001);
                put(8'h23, 16'h8002);
            end
            default: begin
                put(8'h00, 16'h0130); put(8'h01, 16'h0331);
                put(8'h02, 16'h0605); put(8'h03, 16'h0432);
                put(8'h04, 16'h0504); put(8'h05, 16'h0433);
                put(8'h06, 16'h0506);
                put(8'h30, 16'h0002); put(8'h31, 16'h0005);
            end
        endcase
    endtask

    task automatic run_prog(input int which, input int n_instr);
        logic [7:0]  p, np, x, op;
        logic [15:0] a, na, w;
        string tag;
        @(negedge clk);
        rst_n = 1'b0;
        load_prog(which);
        repeat (2) @(negedge clk);
        chk("R1", "pc in reset", pc_o, 0);
        chk("R1", "acc in reset", acc_o, 0);
        rst_n = 1'b1;
        #1;
        chk("R1", "addr after release", mem_addr, 0);
        chk("R1", "we after release", mem_we, 0);
        p = 8'h00;
        a = 16'h0000;
        for (int k = 0; k < n_instr; k++) begin
            @(negedge clk);
            w  = ref_ram[p];
            op = w[15:8];
            x  = w[7:0];
            np = p + 8'd1;
            na = a;
            case (op)
                8'h01: begin tag = "R3"; na = ref_ram[x]; end
                8'h02: begin tag = "R4"; na = a + ref_ram[x]; end
                8'h03: begin tag = "R5"; na = a - ref_ram[x]; end
                8'h04: tag = "R6";
                8'h05: begin tag = "R7"; np = x; end
                8'h06: begin
                    if (a[15]) begin tag = "R8"; np = x; end
                    else tag = "R9";
                end
                default: tag = "R10";
            endcase
            chk("R2", "decode pc", pc_o, p);
            chk("R2", "decode addr", mem_addr, x);
            chk(tag, "decode acc", acc_o, a);
            chk(tag, "decode we", mem_we, 0);
            @(negedge clk);
            chk(tag, "pc after decode", pc_o, np);
            chk(tag, "acc hold", acc_o, a);
            chk(tag, "we second cycle", mem_we, (op == 8'h04));
            chk(tag, "addr second cycle", mem_addr, (op == 8'h04) ? x : np);
            if (op == 8'h04) begin
                chk("R6", "write data", mem_wdata, a);
                ref_ram[x] = a;
                @(negedge clk);
                chk("R6", "we dropped", mem_we, 0);
                chk("R6", "addr restored", mem_addr, np);
            end
            p = np;
            a = na;
        end
        for (int i = 0; i < 256; i++) begin
            if (ram[i] !== ref_ram[i]) chk("R6", "memory word", ram[i], ref_ram[i]);
        end
    endtask

    task automatic main;
        run_prog(0, 6);
        chk("R11", "sum at 0x12", ram[8'h12], 16'h1DEF);
        run_prog(1, 14);
        chk("R8", "skipped store untouched", ram[8'h21], 16'h0000);
        chk("R4", "wrapped sum stored", ram[8'h24], 16'h0001);
        chk("R10", "no-op kept acc", ram[8'h25], 16'h0001);
        chk("R7", "held at self loop", pc_o, 8'h0B);
        run_prog(2, 7);
        chk("R5", "wrapped difference stored", ram[8'h33], 16'hFFFD);
        chk("R8", "taken branch skipped store", ram[8'h32], 16'h0000);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired actual %0d expected 0", 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule